// File: doc/BRIEF.md
# Branch and Next-IP Unit

This block holds the 32-bit instruction pointer and works out, for each decoded instruction, where execution continues. An instruction is one 32-bit word, optionally followed by a 32-bit immediate word, so plain flow advances by 4 or 8 bytes. Unconditional transfers take either the immediate or a register value as the target, depending on whether the register index field is zero. The link form also hands back the address of the following instruction for register write-back.

Conditional branches compare two 64-bit register operands. The comparison width and signedness come from a type selector. A taken branch adds the signed immediate to the address of the current instruction.

The pipeline presents one decoded instruction per cycle together with `valid_i`. The unit drives the combinational next address, the taken flag and the link write-back. The registered pointer advances on each clock edge at which `valid_i` is high.

Top module: `next_ip_unit`

## Requirements
- R1: After reset (`rst_ni` low) `ip_o` is 0.
- R2: Every opcode other than 2..7 (including Nop=0 and generic=1, and 8..15) gives `next_ip_o` = `ip_o`+4 when `has_imm_i`=0 and `ip_o`+8 when `has_imm_i`=1, with `taken_o`=0.
- R3: Jump (op 2) gives `taken_o`=1 and `next_ip_o` = `imm_i` when `r1_idx_i`=0, otherwise `opa_i[31:0]`.
- R4: Link (op 3) selects its target exactly like Jump and sets `taken_o`=1. It drives `link_we_o`=`valid_i` and `link_data_o` = `ip_o`+4 (no immediate) or `ip_o`+8 (immediate present).
- R5: Beq (op 4) is taken when the operands are equal and Bne (op 5) when they differ. Type codes 0 (I4) and 2 (U4) compare only bits 31:0; type codes 1 (I8) and 3 (U8) compare all 64 bits.
- R6: Ble (op 6, less or equal) and Blt (op 7, less than) compare `opa_i` against `opb_i`. The comparison is signed for type 0 (I4) and type 1 (I8) and unsigned for type 2 (U4) and type 3 (U8), at the width given in R5.
- R7: A taken conditional branch gives `next_ip_o` = `ip_o` + `imm_i`, with `imm_i` taken as two's complement and the sum wrapping modulo 2^32. A branch that is not taken gives the sequential address of R2 with `taken_o`=0.
- R8: `ip_o` loads `next_ip_o` on a rising clock edge where `valid_i`=1 and holds otherwise.
- R9: `link_we_o` is 0 for every opcode other than Link, and 0 whenever `valid_i`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Decoded instruction present this cycle |
| op_i | input | 4 | Control opcode: 0 nop, 1 generic, 2 jump, 3 link, 4 beq, 5 bne, 6 ble, 7 blt |
| type_i | input | 2 | Compare type: 0 I4, 1 I8, 2 U4, 3 U8 |
| has_imm_i | input | 1 | Instruction carries an immediate word |
| imm_i | input | 32 | Immediate word (target or signed offset) |
| r1_idx_i | input | 8 | r1 register index field |
| opa_i | input | 64 | REG(r1) for jump/link, REG(r2) for branches |
| opb_i | input | 64 | REG(r3) for branches |
| ip_o | output | 32 | Current instruction pointer |
| next_ip_o | output | 32 | Next instruction pointer |
| taken_o | output | 1 | Control transfer taken |
| link_we_o | output | 1 | Link write-back enable |
| link_data_o | output | 32 | Link write-back value (return address) |

## Verification
A wrong comparison or type decode appears on `taken_o` and `next_ip_o` in the same cycle as the instruction. A bad pointer register appears on `ip_o` one edge later. After that, every later sequential address is offset by the same error. The bench therefore checks the combinational outputs before each edge and `ip_o` after it. Random operands are mixed with directed cases at the 32/64-bit and signed/unsigned boundaries.

// File: rtl/nip_pkg.sv
package nip_pkg;
  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,
    OP_GEN  = 4'd1,
    OP_JUMP = 4'd2,
    OP_LINK = 4'd3,
    OP_BEQ  = 4'd4,
    OP_BNE  = 4'd5,
    OP_BLE  = 4'd6,
    OP_BLT  = 4'd7
  } nip_op_e;

  typedef enum logic [1:0] {
    TY_I4 = 2'd0,
    TY_I8 = 2'd1,
    TY_U4 = 2'd2,
    TY_U8 = 2'd3
  } nip_ty_e;

  typedef struct packed {
    logic eq;
    logic lt;
  } nip_cmp_t;
endpackage

// File: rtl/nip_seq.sv
module nip_seq #(
  parameter int IP_W       = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic [IP_W-1:0] ip_i,
  input  logic            has_imm_i,
  output logic [IP_W-1:0] seq_o
);
  localparam logic [IP_W-1:0] STEP1 = IP_W'(WORD_BYTES);
  localparam logic [IP_W-1:0] STEP2 = IP_W'(2 * WORD_BYTES);

  assign seq_o = ip_i + (has_imm_i ? STEP2 : STEP1);
endmodule

// File: rtl/nip_cmp.sv
module nip_cmp
  import nip_pkg::*;
#(
  parameter int REG_W    = 64,
  parameter int NARROW_W = 32
) (
  input  logic [REG_W-1:0] a_i,
  input  logic [REG_W-1:0] b_i,
  input  logic [1:0]       type_i,
  output nip_cmp_t         res_o
);
  localparam int NW = 2;

  logic [NW-1:0] eq_w, ltu_w, lts_w;

  genvar g;
  for (g = 0; g < NW; g++) begin : g_width
    localparam int W = (g == 0) ? NARROW_W : REG_W;
    logic [W-1:0] a, b;
    assign a        = a_i[W-1:0];
    assign b        = b_i[W-1:0];
    assign eq_w[g]  = (a == b);
    assign ltu_w[g] = (a < b);
    assign lts_w[g] = ($signed(a) < $signed(b));
  end

  nip_ty_e ty;
  logic    wide, is_signed;
  assign ty        = nip_ty_e'(type_i);
  assign wide      = (ty == TY_I8) || (ty == TY_U8);
  assign is_signed = (ty == TY_I4) || (ty == TY_I8);

  assign res_o.eq = eq_w[wide];
  assign res_o.lt = is_signed ? lts_w[wide] : ltu_w[wide];

  // R5/R6: equal and less-than are mutually exclusive
  always_comb begin
    p_eq_lt_excl_r6: assert (!(res_o.eq && res_o.lt) || $isunknown({a_i, b_i, type_i}));
  end
endmodule

// File: rtl/nip_tgt.sv
module nip_tgt #(
  parameter int IP_W  = 32,
  parameter int IDX_W = 8
) (
  input  logic [IP_W-1:0]  ip_i,
  input  logic [IP_W-1:0]  imm_i,
  input  logic [IDX_W-1:0] r1_idx_i,
  input  logic [IP_W-1:0]  reg_tgt_i,
  output logic [IP_W-1:0]  jmp_tgt_o,
  output logic [IP_W-1:0]  br_tgt_o
);
  assign jmp_tgt_o = (r1_idx_i == '0) ? imm_i : reg_tgt_i;
  // two's-complement add wraps modulo 2^IP_W
  assign br_tgt_o  = ip_i + imm_i;
endmodule

// File: rtl/next_ip_unit.sv
module next_ip_unit
  import nip_pkg::*;
#(
  parameter int IP_W       = 32,
  parameter int REG_W      = 64,
  parameter int IDX_W      = 8,
  parameter int NARROW_W   = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [3:0]       op_i,
  input  logic [1:0]       type_i,
  input  logic             has_imm_i,
  input  logic [IP_W-1:0]  imm_i,
  input  logic [IDX_W-1:0] r1_idx_i,
  input  logic [REG_W-1:0] opa_i,
  input  logic [REG_W-1:0] opb_i,
  output logic [IP_W-1:0]  ip_o,
  output logic [IP_W-1:0]  next_ip_o,
  output logic             taken_o,
  output logic             link_we_o,
  output logic [IP_W-1:0]  link_data_o
);
  logic [IP_W-1:0] ip_q, seq_ip, jmp_tgt, br_tgt, nxt;
  nip_cmp_t        cmp;
  nip_op_e         op;
  logic            tkn;

  assign op = nip_op_e'(op_i);

  nip_seq #(.IP_W(IP_W), .WORD_BYTES(WORD_BYTES)) u_seq (
    .ip_i      (ip_q),
    .has_imm_i (has_imm_i),
    .seq_o     (seq_ip)
  );

  nip_cmp #(.REG_W(REG_W), .NARROW_W(NARROW_W)) u_cmp (
    .a_i    (opa_i),
    .b_i    (opb_i),
    .type_i (type_i),
    .res_o  (cmp)
  );

  nip_tgt #(.IP_W(IP_W), .IDX_W(IDX_W)) u_tgt (
    .ip_i      (ip_q),
    .imm_i     (imm_i),
    .r1_idx_i  (r1_idx_i),
    .reg_tgt_i (opa_i[IP_W-1:0]),
    .jmp_tgt_o (jmp_tgt),
    .br_tgt_o  (br_tgt)
  );

  always_comb begin
    tkn = 1'b0;
    nxt = seq_ip;
    case (op)
      OP_JUMP, OP_LINK: begin
        tkn = 1'b1;
        nxt = jmp_tgt;
      end
      OP_BEQ, OP_BNE, OP_BLE, OP_BLT: begin
        case (op)
          OP_BEQ:  tkn = cmp.eq;
          OP_BNE:  tkn = !cmp.eq;
          OP_BLE:  tkn = cmp.eq || cmp.lt;
          default: tkn = cmp.lt;
        endcase
        if (tkn) nxt = br_tgt;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ip_q <= '0;
    else if (valid_i) ip_q <= nxt;
  end

  assign ip_o        = ip_q;
  assign next_ip_o   = nxt;
  assign taken_o     = tkn;
  assign link_we_o   = valid_i && (op == OP_LINK);
  assign link_data_o = seq_ip;

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(ip_q));
  p_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> ip_q == $past(next_ip_o));
  p_jump_taken_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_JUMP || op == OP_LINK) |-> taken_o);
  p_link_only_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_we_o |-> (valid_i && op_i == 4'd3));
  p_not_taken_seq_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !taken_o |-> (next_ip_o - ip_o == IP_W'(WORD_BYTES) ||
                  next_ip_o - ip_o == IP_W'(2 * WORD_BYTES)));
endmodule

// File: tb/next_ip_unit_bench.sv
module next_ip_unit_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic [1:0]  type_i = '0;
  logic        has_imm_i = 1'b0;
  logic [31:0] imm_i = '0;
  logic [7:0]  r1_idx_i = '0;
  logic [63:0] opa_i = '0, opb_i = '0;
  logic [31:0] ip_o, next_ip_o, link_data_o;
  logic        taken_o, link_we_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] mip = '0;

  always #2.5 clk_i = ~clk_i;

  next_ip_unit u_next_ip_unit (
    .clk_i, .rst_ni, .valid_i, .op_i, .type_i, .has_imm_i, .imm_i,
    .r1_idx_i, .opa_i, .opb_i, .ip_o, .next_ip_o, .taken_o,
    .link_we_o, .link_data_o
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] f_seq(logic [31:0] ip, logic hi);
    return ip + (hi ? 32'd8 : 32'd4);
  endfunction

  function automatic logic f_cond(logic [3:0] op, logic [1:0] ty, logic [63:0] a, logic [63:0] b);
    logic eq, lt;
    case (ty)
      2'd0: begin eq = a[31:0] == b[31:0]; lt = $signed(a[31:0]) < $signed(b[31:0]); end
      2'd1: begin eq = a == b;             lt = $signed(a) < $signed(b); end
      2'd2: begin eq = a[31:0] == b[31:0]; lt = a[31:0] < b[31:0]; end
      default: begin eq = a == b;          lt = a < b; end
    endcase
    case (op)
      4'd4: return eq;
      4'd5: return !eq;
      4'd6: return eq || lt;
      default: return lt;
    endcase
  endfunction

  task automatic step(string req, logic v, logic [3:0] op, logic [1:0] ty, logic hi,
                      logic [31:0] imm, logic [7:0] idx, logic [63:0] a, logic [63:0] b);
    logic [31:0] en;
    logic        et;
    @(negedge clk_i);
    valid_i = v; op_i = op; type_i = ty; has_imm_i = hi; imm_i = imm;
    r1_idx_i = idx; opa_i = a; opb_i = b;
    #1;
    en = f_seq(mip, hi); et = 1'b0;
    if (op == 4'd2 || op == 4'd3) begin
      et = 1'b1; en = (idx == 0) ? imm : a[31:0];
    end else if (op >= 4'd4 && op <= 4'd7) begin
      et = f_cond(op, ty, a, b);
      if (et) en = mip + imm;
    end
    chk({req, " next_ip"}, next_ip_o, en);
    chk({req, " taken"}, {31'd0, taken_o}, {31'd0, et});
    chk({req, " R9 link_we"}, {31'd0, link_we_o}, {31'd0, v && op == 4'd3});
    if (op == 4'd3) chk({req, " R4 link_data"}, link_data_o, f_seq(mip, hi));
    @(posedge clk_i); #1;
    if (v) mip = en;
    chk({req, " R8 ip"}, ip_o, mip);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    #7;
    chk("R1 reset ip", ip_o, 32'd0);
    rst_ni = 1'b1;
    // R2 sequential
    step("R2 nop", 1, 4'd0, 0, 0, 32'h0, 0, 0, 0);
    step("R2 gen imm", 1, 4'd1, 0, 1, 32'h1234, 0, 0, 0);
    step("R2 op9", 1, 4'd9, 0, 0, 32'hffff_0000, 0, 0, 0);
    // R3 jump
    step("R3 jump imm", 1, 4'd2, 0, 1, 32'h0000_1000, 8'd0, 64'hdead_beef_0000_2000, 0);
    step("R3 jump reg", 1, 4'd2, 0, 0, 32'h0000_4000, 8'd5, 64'hdead_beef_0000_2000, 0);
    // R4 link
    step("R4 link imm", 1, 4'd3, 0, 1, 32'h0000_3000, 8'd0, 0, 0);
    step("R4 link reg", 1, 4'd3, 0, 0, 32'h0, 8'd1, 64'h0000_0000_0000_0100, 0);
    // R5 narrow equality ignores upper half
    step("R5 beq U4 upper", 1, 4'd4, 2'd2, 1, 32'h40, 0, 64'h1111_1111_0000_00aa, 64'h2222_2222_0000_00aa);
    step("R5 beq U8 upper", 1, 4'd4, 2'd3, 1, 32'h40, 0, 64'h1111_1111_0000_00aa, 64'h2222_2222_0000_00aa);
    step("R5 bne U8", 1, 4'd5, 2'd3, 1, 32'hffff_fff0, 0, 64'h1, 64'h2);
    // R6 signedness
    step("R6 blt I4 neg", 1, 4'd7, 2'd0, 1, 32'h20, 0, 64'h0000_0000_8000_0000, 64'h1);
    step("R6 blt U4 big", 1, 4'd7, 2'd2, 1, 32'h20, 0, 64'h0000_0000_8000_0000, 64'h1);
    step("R6 blt I8 neg", 1, 4'd7, 2'd1, 1, 32'h20, 0, 64'h8000_0000_0000_0000, 64'h1);
    step("R6 ble U8 eq", 1, 4'd6, 2'd3, 1, 32'h100, 0, 64'h55, 64'h55);
    step("R6 blt U8 eq", 1, 4'd7, 2'd3, 1, 32'h100, 0, 64'h55, 64'h55);
    // R7 backward branch
    step("R7 bne back", 1, 4'd5, 2'd1, 1, 32'hffff_ff00, 0, 64'h3, 64'h4);
    // R8 hold
    step("R8 hold jump", 0, 4'd2, 0, 1, 32'h9999_0000, 0, 0, 0);
    step("R8 hold nop", 0, 4'd0, 0, 0, 32'h0, 0, 0, 0);
    for (int i = 0; i < 400; i++) begin
      logic [63:0] a, b;
      logic [3:0]  op;
      a  = {$urandom, $urandom};
      b  = ($urandom_range(0, 2) == 0) ? a : {$urandom, $urandom};
      if ($urandom_range(0, 3) == 0) b[31:0] = a[31:0];
      op = 4'($urandom_range(0, 9));
      step("R7 random", ($urandom_range(0, 7) != 0), op, 2'($urandom_range(0, 3)),
           1'($urandom_range(0, 1)), $urandom, 8'($urandom_range(0, 3)), a, b);
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule